// File: doc/BRIEF.md
# CAN Receive Buffer Selector

This block sits between a CAN protocol engine and a bank of receive message buffers. When the engine signals that a frame has been fully received, the block compares the frame's identifier against every buffer's programmed identifier and picks the single buffer that will take the frame. Each buffer's 2-bit filter-mode field decides how its identifier is compared. The compare can be exact, it can apply one of two shared mask words, or it can accept any identifier. Payload storage is handled elsewhere. It uses the store strobe and the winning index that this block produces.

The choice is made in two tiers, with the lowest index winning within a tier. The first tier holds accepting buffers that are either still unread or filtered in exact mode. If the first tier is empty, the lowest-numbered accepting buffer is used. On every store, the block updates four per-buffer status vectors: receive done, overrun, remote request seen, and pending transmit request. Data frames and remote frames affect pending transmit requests in different ways. A request whose frame is already on the bus is never withdrawn.

Top module: `rxbuf_select`

## Requirements
- R1: With filter mode 00 a buffer accepts a frame only if all identifier bits equal the buffer identifier.
- R2: Filter mode 01 ignores identifier bits where shared mask 0 is 1, and mode 10 does the same with shared mask 1. All other bits must match.
- R3: Filter mode 11 accepts any identifier.
- R4: Among accepting buffers that have receive-done 0 or filter mode 00, the lowest-numbered one is chosen.
- R5: If no accepting buffer qualifies under R4, the lowest-numbered accepting buffer is chosen.
- R6: If no buffer accepts the frame, `storeValid` stays 0 and no status bit changes.
- R7: When `frameDone` is sampled high at a clock edge and some buffer accepts, `storeValid` is 1 and `storeIdx` holds the chosen index after that edge, for exactly one cycle. The chosen buffer's receive-done bit is 1 after that same edge.
- R8: If the chosen buffer's receive-done bit was already 1 when the frame is stored, its overrun bit becomes 1.
- R9: A stored data frame (`frameRemote`=0) clears the chosen buffer's remote-request bit. It also clears the buffer's pending transmit request.
- R10: A stored remote frame sets the chosen buffer's remote-request bit. It clears the pending transmit request only when that buffer's `txRemote` bit is 1.
- R11: A pending transmit request is never cleared by a store while that buffer's `txBusy` bit is 1.
- R12: `rcClear` and `ovrClear` clear receive-done and overrun bits, and a store to the same buffer in the same cycle wins over the clear. `txReqSet` sets a transmit request, and `txReqClr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameDone | input | 1 | One-cycle end-of-frame strobe from the protocol engine |
| frameId | input | ID_W | Identifier of the received frame |
| frameRemote | input | 1 | 1 = remote frame, 0 = data frame |
| bufId | input | NBUF*ID_W | Identifier of each buffer, buffer i at bits [i*ID_W +: ID_W] |
| bufMode | input | NBUF*2 | Filter mode of each buffer, buffer i at bits [2*i +: 2] |
| sharedMask0 | input | ID_W | Shared mask word used by filter mode 01 |
| sharedMask1 | input | ID_W | Shared mask word used by filter mode 10 |
| txRemote | input | NBUF | Per buffer: its pending request is for a remote frame |
| txBusy | input | NBUF | Per buffer: its frame is already being transmitted |
| txReqSet | input | NBUF | Set pending transmit request |
| txReqClr | input | NBUF | Clear pending transmit request |
| rcClear | input | NBUF | Clear receive-done bit |
| ovrClear | input | NBUF | Clear overrun bit |
| storeValid | output | 1 | Frame is being stored this cycle |
| storeIdx | output | IDX_W | Index of the buffer taking the frame |
| rxDone | output | NBUF | Receive-done status |
| rxOvr | output | NBUF | Overrun status |
| rmtReq | output | NBUF | Remote-request-seen status |
| txReq | output | NBUF | Pending transmit request status |

## Verification
The buffer bank is set up so that every filter mode is in use at once. One identifier is then resent while the target buffers fill up. This shows that the first tier moves on from an unread masked buffer to the next unread one. It also shows that the choice falls back to the lowest accepting buffer once all are read, and that an exact-mode buffer keeps its priority even after it is read. Identifiers that differ only in masked bits, or only in unmasked bits, tell mode 01 and mode 10 apart from exact mode. An identifier that no buffer accepts confirms that nothing is stored. Data frames and remote frames are sent with `txRemote` and `txBusy` set to different values. This separates the cases where a pending transmit request survives a store from the cases where it is cancelled.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef enum logic [1:0] {
    MODE_EXACT = 2'b00,
    MODE_MASK0 = 2'b01,
    MODE_MASK1 = 2'b10,
    MODE_ANY   = 2'b11
  } filterMode_e;

  // Strobes from control into the status datapath
  typedef struct packed {
    logic storeEn;
    logic isRemote;
  } rxStrobe_t;

endpackage

// File: rtl/rxbuf_match.sv
module rxbuf_match #(
  parameter int NBUF  = 8,
  parameter int ID_W  = 11,
  parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [ID_W-1:0]      frameId,
  input  logic [NBUF*ID_W-1:0] bufId,
  input  logic [NBUF*2-1:0]    bufMode,
  input  logic [ID_W-1:0]      sharedMask0,
  input  logic [ID_W-1:0]      sharedMask1,
  input  logic [NBUF-1:0]      rxDone,
  output logic                 anyHit,
  output logic [IDX_W-1:0]     winIdx
);
  import rxbuf_pkg::*;

  logic [NBUF-1:0] hitVec;
  logic [NBUF-1:0] prefVec;

  for (genvar i = 0; i < NBUF; i++) begin : g_cmp
    filterMode_e     mode;
    logic [ID_W-1:0] ignoreBits;
    logic [ID_W-1:0] diffBits;

    assign mode     = filterMode_e'(bufMode[2*i +: 2]);
    assign diffBits = frameId ^ bufId[i*ID_W +: ID_W];

    always_comb begin
      unique case (mode)
        MODE_EXACT: ignoreBits = '0;
        MODE_MASK0: ignoreBits = sharedMask0;
        MODE_MASK1: ignoreBits = sharedMask1;
        default:    ignoreBits = '1;
      endcase
    end

    assign hitVec[i]  = ((diffBits & ~ignoreBits) == '0);
    assign prefVec[i] = hitVec[i] && (!rxDone[i] || mode == MODE_EXACT);
  end

  logic [IDX_W-1:0] prefIdx;
  logic [IDX_W-1:0] hitIdx;

  always_comb begin
    prefIdx = '0;
    hitIdx  = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (prefVec[i]) prefIdx = IDX_W'(i);
      if (hitVec[i])  hitIdx  = IDX_W'(i);
    end
  end

  assign anyHit = |hitVec;
  assign winIdx = (|prefVec) ? prefIdx : hitIdx;

endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
  parameter int NBUF  = 8,
  parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameDone,
  input  logic                 frameRemote,
  input  logic                 anyHit,
  input  logic [IDX_W-1:0]     winIdx,
  output rxbuf_pkg::rxStrobe_t strobe,
  output logic [NBUF-1:0]      winSel,
  output logic                 storeValid,
  output logic [IDX_W-1:0]     storeIdx
);

  assign strobe.storeEn  = frameDone && anyHit;
  assign strobe.isRemote = frameRemote;

  for (genvar i = 0; i < NBUF; i++) begin : g_sel
    assign winSel[i] = strobe.storeEn && (winIdx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storeValid <= 1'b0;
      storeIdx   <= '0;
    end else begin
      storeValid <= strobe.storeEn;
      if (strobe.storeEn) storeIdx <= winIdx;
    end
  end

  // R7
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && anyHit |=> storeValid && storeIdx == $past(winIdx));

  // R6
  no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(frameDone && anyHit) |=> !storeValid);

endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status #(
  parameter int NBUF = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxbuf_pkg::rxStrobe_t strobe,
  input  logic [NBUF-1:0]      winSel,
  input  logic [NBUF-1:0]      txRemote,
  input  logic [NBUF-1:0]      txBusy,
  input  logic [NBUF-1:0]      txReqSet,
  input  logic [NBUF-1:0]      txReqClr,
  input  logic [NBUF-1:0]      rcClear,
  input  logic [NBUF-1:0]      ovrClear,
  output logic [NBUF-1:0]      rxDone,
  output logic [NBUF-1:0]      rxOvr,
  output logic [NBUF-1:0]      rmtReq,
  output logic [NBUF-1:0]      txReq
);

  logic [NBUF-1:0] cancelVec;

  // Data frames cancel any idle request; remote frames only remote requests
  assign cancelVec = winSel & ~txBusy & (strobe.isRemote ? txRemote : {NBUF{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxDone <= '0;
      rxOvr  <= '0;
      rmtReq <= '0;
      txReq  <= '0;
    end else begin
      rxDone <= (rxDone & ~rcClear) | winSel;
      rxOvr  <= (rxOvr & ~ovrClear) | (winSel & rxDone);
      rmtReq <= strobe.isRemote ? (rmtReq | winSel) : (rmtReq & ~winSel);
      txReq  <= (txReq & ~cancelVec & ~txReqClr) | txReqSet;
    end
  end

  for (genvar i = 0; i < NBUF; i++) begin : g_chk
    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      winSel[i] |=> rxDone[i]);

    // R8
    overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
      winSel[i] && rxDone[i] |=> rxOvr[i]);

    // R9
    data_rmt_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      winSel[i] && !strobe.isRemote |=> !rmtReq[i]);

    // R10
    remote_rmt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      winSel[i] && strobe.isRemote |=> rmtReq[i]);

    // R10
    remote_keep_data_req_chk: assert property (@(posedge clk) disable iff (!rstN)
      winSel[i] && strobe.isRemote && !txRemote[i] && txReq[i] && !txReqClr[i]
      |=> txReq[i]);

    // R11
    busy_keep_req_chk: assert property (@(posedge clk) disable iff (!rstN)
      winSel[i] && txBusy[i] && txReq[i] && !txReqClr[i] |=> txReq[i]);

    // R6
    idle_done_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      !winSel[i] && !rcClear[i] |=> $stable(rxDone[i]));
  end

endmodule

// File: rtl/rxbuf_select.sv
module rxbuf_select #(
  parameter int NBUF  = 8,
  parameter int ID_W  = 11,
  parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameDone,
  input  logic [ID_W-1:0]      frameId,
  input  logic                 frameRemote,
  input  logic [NBUF*ID_W-1:0] bufId,
  input  logic [NBUF*2-1:0]    bufMode,
  input  logic [ID_W-1:0]      sharedMask0,
  input  logic [ID_W-1:0]      sharedMask1,
  input  logic [NBUF-1:0]      txRemote,
  input  logic [NBUF-1:0]      txBusy,
  input  logic [NBUF-1:0]      txReqSet,
  input  logic [NBUF-1:0]      txReqClr,
  input  logic [NBUF-1:0]      rcClear,
  input  logic [NBUF-1:0]      ovrClear,
  output logic                 storeValid,
  output logic [IDX_W-1:0]     storeIdx,
  output logic [NBUF-1:0]      rxDone,
  output logic [NBUF-1:0]      rxOvr,
  output logic [NBUF-1:0]      rmtReq,
  output logic [NBUF-1:0]      txReq
);

  rxbuf_pkg::rxStrobe_t strobe;
  logic                 anyHit;
  logic [IDX_W-1:0]     winIdx;
  logic [NBUF-1:0]      winSel;

  rxbuf_match #(.NBUF(NBUF), .ID_W(ID_W), .IDX_W(IDX_W)) u_match (
    .frameId(frameId), .bufId(bufId), .bufMode(bufMode),
    .sharedMask0(sharedMask0), .sharedMask1(sharedMask1),
    .rxDone(rxDone), .anyHit(anyHit), .winIdx(winIdx)
  );

  rxbuf_ctrl #(.NBUF(NBUF), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameRemote(frameRemote),
    .anyHit(anyHit), .winIdx(winIdx), .strobe(strobe), .winSel(winSel),
    .storeValid(storeValid), .storeIdx(storeIdx)
  );

  rxbuf_status #(.NBUF(NBUF)) u_status (
    .clk(clk), .rstN(rstN), .strobe(strobe), .winSel(winSel),
    .txRemote(txRemote), .txBusy(txBusy), .txReqSet(txReqSet),
    .txReqClr(txReqClr), .rcClear(rcClear), .ovrClear(ovrClear),
    .rxDone(rxDone), .rxOvr(rxOvr), .rmtReq(rmtReq), .txReq(txReq)
  );

endmodule

// File: tb/tb_rxbuf_select.sv
module tb_rxbuf_select;
  localparam int NB = 8;
  localparam int IW = 11;
  localparam int XW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameDone = 1'b0;
  logic [IW-1:0] frameId = '0;
  logic frameRemote = 1'b0;
  logic [NB*IW-1:0] bufId = '0;
  logic [NB*2-1:0] bufMode = '0;
  logic [IW-1:0] sharedMask0 = '0, sharedMask1 = '0;
  logic [NB-1:0] txRemote = '0, txBusy = '0, txReqSet = '0, txReqClr = '0;
  logic [NB-1:0] rcClear = '0, ovrClear = '0;
  logic storeValid;
  logic [XW-1:0] storeIdx;
  logic [NB-1:0] rxDone, rxOvr, rmtReq, txReq;

  rxbuf_select #(.NBUF(NB), .ID_W(IW)) dut (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameId(frameId),
    .frameRemote(frameRemote), .bufId(bufId), .bufMode(bufMode),
    .sharedMask0(sharedMask0), .sharedMask1(sharedMask1),
    .txRemote(txRemote), .txBusy(txBusy), .txReqSet(txReqSet),
    .txReqClr(txReqClr), .rcClear(rcClear), .ovrClear(ovrClear),
    .storeValid(storeValid), .storeIdx(storeIdx), .rxDone(rxDone),
    .rxOvr(rxOvr), .rmtReq(rmtReq), .txReq(txReq)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Bench model of the status bits
  logic [NB-1:0] mRx = '0, mOvr = '0, mRmt = '0, mTx = '0;

  typedef struct {
    int idx;
    logic [NB-1:0] rx, ovr, rmt, tx;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkStatus(input string tag);
    chk(rxDone == mRx, {tag, " rxDone"}, 32'(rxDone), 32'(mRx));
    chk(rxOvr == mOvr, {tag, " rxOvr"}, 32'(rxOvr), 32'(mOvr));
    chk(rmtReq == mRmt, {tag, " rmtReq"}, 32'(rmtReq), 32'(mRmt));
    chk(txReq == mTx, {tag, " txReq"}, 32'(txReq), 32'(mTx));
  endtask

  // Driver: push expectation, then present one end-of-frame strobe
  task automatic sendFrame(input logic [IW-1:0] id, input bit remote,
                           input int expIdx, input string tag);
    exp_t e;
    @(negedge clk);
    if (expIdx >= 0) begin
      mOvr[expIdx] = mOvr[expIdx] | mRx[expIdx];
      mRx[expIdx]  = 1'b1;
      mRmt[expIdx] = remote;
      if (!txBusy[expIdx] && (!remote || txRemote[expIdx])) mTx[expIdx] = 1'b0;
    end
    e.idx = expIdx; e.rx = mRx; e.ovr = mOvr; e.rmt = mRmt; e.tx = mTx; e.tag = tag;
    q.push_back(e);
    frameId = id; frameRemote = remote; frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
  endtask

  // Monitor: compare one cycle after each sampled strobe
  initial begin
    forever begin
      @(posedge clk);
      if (frameDone) begin
        exp_t e;
        #1;
        e = q.pop_front();
        chk(storeValid == (e.idx >= 0), {e.tag, " storeValid"},
            32'(storeValid), 32'(e.idx >= 0));
        if (e.idx >= 0)
          chk(storeIdx == XW'(e.idx), {e.tag, " storeIdx"}, 32'(storeIdx), 32'(e.idx));
        chk(rxDone == e.rx, {e.tag, " rxDone"}, 32'(rxDone), 32'(e.rx));
        chk(rxOvr == e.ovr, {e.tag, " rxOvr"}, 32'(rxOvr), 32'(e.ovr));
        chk(rmtReq == e.rmt, {e.tag, " rmtReq"}, 32'(rmtReq), 32'(e.rmt));
        chk(txReq == e.tx, {e.tag, " txReq"}, 32'(txReq), 32'(e.tx));
      end
    end
  end

  task automatic setBuf(input int i, input logic [IW-1:0] id, input logic [1:0] mode);
    bufId[i*IW +: IW] = id;
    bufMode[2*i +: 2] = mode;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish();
  end

  initial begin
    setBuf(0, 11'h100, 2'b00);
    setBuf(1, 11'h120, 2'b01);
    setBuf(2, 11'h200, 2'b10);
    setBuf(3, 11'h100, 2'b01);
    setBuf(4, 11'h300, 2'b00);
    setBuf(5, 11'h000, 2'b11);
    setBuf(6, 11'h120, 2'b00);
    setBuf(7, 11'h7FF, 2'b11);
    sharedMask0 = 11'h00F;
    sharedMask1 = 11'h0F0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(storeValid == 1'b0, "reset storeValid", 32'(storeValid), 0);
    checkStatus("reset");

    sendFrame(11'h100, 0, 0, "R1 R4 exact match first unread");
    sendFrame(11'h105, 0, 3, "R2 R1 mask0 ignores low bits, exact rejects");
    sendFrame(11'h105, 0, 5, "R4 R3 read masked skipped for unread wildcard");
    sendFrame(11'h105, 0, 7, "R4 next unread wildcard");
    sendFrame(11'h105, 0, 3, "R5 R8 fallback lowest accepting with overrun");
    sendFrame(11'h100, 0, 0, "R4 R8 exact mode keeps priority when read");
    sendFrame(11'h250, 0, 2, "R2 mask1 ignores middle bits");
    sendFrame(11'h6AB, 0, 5, "R3 R5 only wildcards accept");

    @(negedge clk); rcClear = '1;
    @(negedge clk); rcClear = '0; mRx = '0;
    checkStatus("R12 rcClear");
    @(negedge clk); ovrClear = '1;
    @(negedge clk); ovrClear = '0; mOvr = '0;
    checkStatus("R12 ovrClear");
    txReqSet = 8'b0101_0000;
    @(negedge clk); txReqSet = '0; mTx = 8'b0101_0000;
    checkStatus("R12 txReqSet");

    sendFrame(11'h300, 1, 4, "R10 remote keeps data request");
    txRemote[4] = 1'b1;
    sendFrame(11'h300, 1, 4, "R10 R8 remote cancels remote request");
    @(negedge clk); txReqSet = 8'b0001_0000;
    @(negedge clk); txReqSet = '0; mTx[4] = 1'b1;
    sendFrame(11'h300, 0, 4, "R9 data clears remote bit and request");

    txBusy[6] = 1'b1;
    sendFrame(11'h120, 0, 1, "R2 mask0 exact bits accept, request elsewhere kept");
    sendFrame(11'h120, 0, 5, "R4 unread wildcard before exact");
    sendFrame(11'h120, 0, 6, "R11 busy buffer keeps request");
    @(negedge clk); txBusy[6] = 1'b0;
    sendFrame(11'h120, 0, 6, "R11 R9 idle request cancelled");

    @(negedge clk); txReqSet = 8'b0000_0100;
    @(negedge clk); txReqSet = '0; mTx[2] = 1'b1;
    checkStatus("R12 set before clear");
    txReqClr = 8'b0000_0100;
    @(negedge clk); txReqClr = '0; mTx[2] = 1'b0;
    checkStatus("R12 txReqClr");
    @(negedge clk); txReqSet = 8'b0000_0100;
    @(negedge clk); txReqSet = '0; mTx[2] = 1'b1;

    setBuf(5, 11'h000, 2'b00);
    setBuf(7, 11'h7FF, 2'b00);
    sendFrame(11'h555, 0, -1, "R6 no buffer accepts");
    @(negedge clk);
    chk(storeValid == 1'b0, "R6 no later store", 32'(storeValid), 0);
    checkStatus("R6 status unchanged");

    repeat (2) @(negedge clk);
    finish();
  end

endmodule